// File: doc/BRIEF.md
# Crossbar Axon Event Dispatcher

This block turns a stream of axon address events into parallel update strobes for a column of neurons. Each axon owns one row of a binary connection matrix, with one bit per neuron, and a small type code (0, 1 or 2) that tells the neurons which synaptic weight to apply. When an event names an axon, the dispatcher reads that axon's row and type. It then raises one update strobe per connected neuron, all in the same cycle, and sends the type beside them.

The input is back-pressured while an event is being served. A new axon index is taken only after the fan-out for the previous one has been issued. A time-step controller watches the idle output and issues its step synchronization only when no event is in flight. The connection rows and the type codes are written through a simple configuration port. Both stores clear to zero on reset.

Top module: `axon_fanout_dispatch`

## Requirements
- R1: After reset, evt_ready and idle are 1, upd_valid is 0, upd_strobe is all zeros, and every stored row and type reads as zero.
- R2: An event is taken on a rising edge where evt_valid and evt_ready are both 1. evt_ready is then 0 for the next two cycles and returns to 1 in the third cycle.
- R3: For an in-range event taken at edge t, upd_valid is 1 for exactly one cycle, the cycle after edge t+1.
- R4: While upd_valid is 1, bit i of upd_strobe equals the stored connection bit of the event's axon for neuron i. Bit 0 is neuron 0.
- R5: While upd_valid is 1, upd_type equals the 2-bit type stored for the event's axon.
- R6: An event whose axon index is K or more is taken with the same ready timing. It produces no upd_valid pulse.
- R7: idle is 1 exactly when no event is in flight. It is 0 in the two cycles after acceptance, including the cycle in which the update is issued.
- R8: A cycle with cfg_we high and cfg_axon below K replaces that axon's whole row with cfg_row and its type with cfg_type. Later events see the new values.
- R9: A configuration write with cfg_axon of K or more changes no stored row or type.
- R10: upd_strobe is all zeros in every cycle where upd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | An axon event is offered |
| evt_ready | output | 1 | The dispatcher can take an event this cycle |
| evt_axon | input | IDX_W | Axon index of the offered event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_axon | input | IDX_W | Axon whose row and type are written |
| cfg_row | input | N | Connection bits, bit i for neuron i |
| cfg_type | input | 2 | Axon type code |
| upd_valid | output | 1 | One-cycle pulse that marks an update |
| upd_strobe | output | N | Per-neuron update strobes |
| upd_type | output | 2 | Type of the axon being fanned out |
| idle | output | 1 | No event in flight |

## Verification
The hardest cases to reach are the ones where the input gives no sign of an error. An out-of-range event must still hold off evt_ready for the full two cycles, yet it must never pulse upd_valid. Likewise, an out-of-range configuration write must leave the row it would alias untouched. The stimulus first writes a distinctive row to an axon. It then writes all ones to the index K plus that axon, fires an event on the original axon, and checks that the old row comes back. It also sends indices K and 2K−1 while the scoreboard expects nothing, so any stray pulse meets an empty queue.

// File: rtl/axdisp_pkg.sv
package axdisp_pkg;

    localparam int TYPE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EMIT = 2'd2
    } disp_state_e;

endpackage

// File: rtl/xbar_store.sv
module xbar_store
    import axdisp_pkg::*;
#(
    parameter int K     = 64,
    parameter int N     = 16,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [N-1:0]      wr_row,
    input  logic [TYPE_W-1:0] wr_type,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [N-1:0]      rd_row,
    output logic [TYPE_W-1:0] rd_type,
    output logic              rd_hit
);

    localparam int SEL_W = (K > 1) ? $clog2(K) : 1;

    logic [N-1:0]      row_q  [K];
    logic [TYPE_W-1:0] type_q [K];

    for (genvar r = 0; r < K; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[r]  <= '0;
                type_q[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                row_q[r]  <= wr_row;
                type_q[r] <= wr_type;
            end
        end
    end

    logic [SEL_W-1:0] sel;

    always_comb begin
        rd_hit  = ({1'b0, rd_idx} < (IDX_W+1)'(K));
        sel     = rd_idx[SEL_W-1:0];
        rd_row  = '0;
        rd_type = '0;
        if (rd_hit) begin
            rd_row  = row_q[sel];
            rd_type = type_q[sel];
        end
    end

endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
    import axdisp_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [IDX_W-1:0]  evt_axon,
    output logic              evt_ready,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [N-1:0]      rd_row,
    input  logic [TYPE_W-1:0] rd_type,
    input  logic              rd_hit,
    output logic              upd_valid,
    output logic [N-1:0]      upd_strobe,
    output logic [TYPE_W-1:0] upd_type,
    output logic              idle
);

    typedef struct packed {
        disp_state_e       state;
        logic [IDX_W-1:0]  idx;
        logic              valid;
        logic [N-1:0]      strobe;
        logic [TYPE_W-1:0] typ;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.valid  = 1'b0;
        nxt_d.strobe = '0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (evt_valid) begin
                    nxt_d.idx   = evt_axon;
                    nxt_d.state = ST_READ;
                end
            end
            ST_READ: begin
                nxt_d.valid  = rd_hit;
                nxt_d.strobe = rd_hit ? rd_row : '0;
                nxt_d.typ    = rd_hit ? rd_type : '0;
                nxt_d.state  = ST_EMIT;
            end
            ST_EMIT: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, idx: '0, valid: 1'b0, strobe: '0, typ: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign evt_ready  = (cur_q.state == ST_IDLE);
    assign idle       = (cur_q.state == ST_IDLE);
    assign rd_idx     = cur_q.idx;
    assign upd_valid  = cur_q.valid;
    assign upd_strobe = cur_q.strobe;
    assign upd_type   = cur_q.typ;

endmodule

// File: rtl/axon_fanout_dispatch.sv
module axon_fanout_dispatch
    import axdisp_pkg::*;
#(
    parameter int K     = 64,
    parameter int N     = 16,
    parameter int IDX_W = $clog2(K) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [IDX_W-1:0]  evt_axon,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_axon,
    input  logic [N-1:0]      cfg_row,
    input  logic [TYPE_W-1:0] cfg_type,
    output logic              upd_valid,
    output logic [N-1:0]      upd_strobe,
    output logic [TYPE_W-1:0] upd_type,
    output logic              idle
);

    logic [IDX_W-1:0]  rd_idx;
    logic [N-1:0]      rd_row;
    logic [TYPE_W-1:0] rd_type;
    logic              rd_hit;

    xbar_store #(.K(K), .N(N), .IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_axon),
        .wr_row  (cfg_row),
        .wr_type (cfg_type),
        .rd_idx  (rd_idx),
        .rd_row  (rd_row),
        .rd_type (rd_type),
        .rd_hit  (rd_hit)
    );

    dispatch_ctrl #(.N(N), .IDX_W(IDX_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_axon   (evt_axon),
        .evt_ready  (evt_ready),
        .rd_idx     (rd_idx),
        .rd_row     (rd_row),
        .rd_type    (rd_type),
        .rd_hit     (rd_hit),
        .upd_valid  (upd_valid),
        .upd_strobe (upd_strobe),
        .upd_type   (upd_type),
        .idle       (idle)
    );

endmodule

// File: rtl/axon_fanout_dispatch_chk.sv
module axon_fanout_dispatch_chk #(
    parameter int K     = 64,
    parameter int N     = 16,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic             evt_ready,
    input logic [IDX_W-1:0] evt_axon,
    input logic             cfg_we,
    input logic [IDX_W-1:0] cfg_axon,
    input logic [N-1:0]     cfg_row,
    input logic [1:0]       cfg_type,
    input logic             upd_valid,
    input logic [N-1:0]     upd_strobe,
    input logic [1:0]       upd_type,
    input logic             idle
);

    // R2: ready drops right after an acceptance
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> !evt_ready);

    // R3: the update pulse lasts a single cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    // R3: an update is always preceded by an acceptance two edges earlier
    a_r3_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(evt_valid && evt_ready, 2));

    // R6: an out-of-range index yields no pulse
    a_r6_drop_range: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && ({1'b0, evt_axon} >= (IDX_W+1)'(K))) |=> ##1 !upd_valid);

    // R7: the dispatcher is busy while issuing an update
    a_r7_busy_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (!idle && !evt_ready));

    // R10: no strobe bit without the valid flag
    a_r10_quiet_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> (upd_strobe == '0));

endmodule

bind axon_fanout_dispatch axon_fanout_dispatch_chk #(.K(K), .N(N), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/axon_fanout_dispatch_tb_top.sv
`timescale 1ns/1ps
module axon_fanout_dispatch_tb_top;

    localparam int K     = 64;
    localparam int N     = 16;
    localparam int IDX_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_valid = 1'b0;
    logic             evt_ready;
    logic [IDX_W-1:0] evt_axon = '0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_axon = '0;
    logic [N-1:0]     cfg_row = '0;
    logic [1:0]       cfg_type = '0;
    logic             upd_valid;
    logic [N-1:0]     upd_strobe;
    logic [1:0]       upd_type;
    logic             idle;

    always #2.5 clk = ~clk;

    axon_fanout_dispatch #(.K(K), .N(N), .IDX_W(IDX_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_ready  (evt_ready),
        .evt_axon   (evt_axon),
        .cfg_we     (cfg_we),
        .cfg_axon   (cfg_axon),
        .cfg_row    (cfg_row),
        .cfg_type   (cfg_type),
        .upd_valid  (upd_valid),
        .upd_strobe (upd_strobe),
        .upd_type   (upd_type),
        .idle       (idle)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [N-1:0] ref_row  [K];
    logic [1:0]   ref_type [K];
    logic [N-1:0] exp_row_q  [$];
    logic [1:0]   exp_type_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [N-1:0] row, input logic [1:0] t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_axon = IDX_W'(a); cfg_row = row; cfg_type = t;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < K) begin   // R8 model; R9 drops the rest
            ref_row[a]  = row;
            ref_type[a] = t;
        end
    endtask

    task automatic send_evt(input int a);
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        evt_valid = 1'b1;
        evt_axon  = IDX_W'(a);
        if (a < K) begin
            exp_row_q.push_back(ref_row[a]);
            exp_type_q.push_back(ref_type[a]);
        end
        @(negedge clk);
        evt_valid = 1'b0;
        check(evt_ready == 1'b0, "R2", "ready after accept", 32'(evt_ready), 0);
        check(idle == 1'b0, "R7", "idle after accept", 32'(idle), 0);
        check(upd_valid == 1'b0, "R3", "early update", 32'(upd_valid), 0);
        @(negedge clk);
        check(evt_ready == 1'b0, "R2", "ready second busy cycle", 32'(evt_ready), 0);
        check(idle == 1'b0, "R7", "idle second busy cycle", 32'(idle), 0);
        if (a < K) check(upd_valid == 1'b1, "R3", "update pulse", 32'(upd_valid), 1);
        else       check(upd_valid == 1'b0, "R6", "out-of-range pulse", 32'(upd_valid), 0);
        @(negedge clk);
        check(evt_ready == 1'b1, "R2", "ready returns", 32'(evt_ready), 1);
        check(idle == 1'b1, "R7", "idle returns", 32'(idle), 1);
        check(upd_valid == 1'b0, "R3", "pulse width", 32'(upd_valid), 0);
    endtask

    // monitor: pops the scoreboard whenever an update appears
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (upd_valid) begin
                if (exp_row_q.size() == 0) begin
                    check(1'b0, "R6", "update with nothing expected", 32'(upd_strobe), 0);
                end else begin
                    logic [N-1:0] er;
                    logic [1:0]   et;
                    er = exp_row_q.pop_front();
                    et = exp_type_q.pop_front();
                    check(upd_strobe == er, "R4", "strobe vector", 32'(upd_strobe), 32'(er));
                    check(upd_type == et, "R5", "axon type", 32'(upd_type), 32'(et));
                end
            end else begin
                check(upd_strobe == '0, "R10", "strobe without valid", 32'(upd_strobe), 0);
            end
        end
    end

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < K; i++) begin
            ref_row[i]  = '0;
            ref_type[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(evt_ready == 1'b1, "R1", "reset ready", 32'(evt_ready), 1);
        check(idle == 1'b1, "R1", "reset idle", 32'(idle), 1);
        check(upd_valid == 1'b0, "R1", "reset valid", 32'(upd_valid), 0);
        check(upd_strobe == '0, "R1", "reset strobe", 32'(upd_strobe), 0);

        // R1: cleared store yields a pulse with empty strobes
        send_evt(10);
        send_evt(63);

        // R4 R5: distinct patterns
        cfg_write(0, 16'hA5A5, 2'd1);
        cfg_write(63, 16'h8001, 2'd2);
        cfg_write(7, 16'hFFFF, 2'd0);
        cfg_write(20, 16'h0001, 2'd2);
        send_evt(0);
        send_evt(63);
        send_evt(7);
        send_evt(20);

        // R6: out-of-range events
        send_evt(K);
        send_evt(2*K - 1);
        send_evt(20);

        // R8: overwrite
        cfg_write(7, 16'h0F0F, 2'd2);
        send_evt(7);

        // R9: aliasing write above range
        cfg_write(K + 7, 16'hFFFF, 2'd1);
        cfg_write(K + 20, 16'hF0F0, 2'd0);
        send_evt(7);
        send_evt(20);

        // full sweep
        for (int a = 0; a < K; a++)
            cfg_write(a, N'((a * 37 + 5) ^ (a << 8)), 2'(a % 3));
        for (int a = 0; a < K; a++)
            send_evt(a);

        repeat (4) @(negedge clk);
        check(exp_row_q.size() == 0, "R3", "missing updates", 32'(exp_row_q.size()), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule